// File: doc/BRIEF.md
# Multi-Channel Prescaled Timer Unit

The unit holds up to seven independent 32-bit down-counters that all advance on a common time base. A shared prescaler counts down once per clock. When it reaches zero it reloads from its reload register and emits a one-cycle tick. On each tick, every enabled timer decrements. A timer that is already at zero when a tick arrives underflows. On underflow it either reloads, when restart is set, or stops. It can also latch a pending flag and pulse an interrupt line.

Software reaches every register through a simple APB-style port, with word addresses decoded from `paddr[7:2]`. The interrupt outputs form a 32-line vector. All timers either share one line given by a base number, or timer n drives line base+n. The pending flag is cleared in one of two ways, fixed at build time: write a 1 to it, or write a word whose bit 4 is 0.

Top module: `ptmr_unit`

## Requirements
- R1: After reset, the scaler value, scaler reload and every timer's counter, reload and control read as 0, and `irq_o` is 0.
- R2: Address 0x00 reads the scaler value and address 0x04 reads the scaler reload; both are writable. Each clock, the value decrements. In a cycle where it is 0, it raises the tick and takes the reload value instead, so the tick period is reload+1 cycles. A write to 0x00 overrides the count.
- R3: Timer n's counter (0x10*(n+1)), reload (+4) and control (+8) are read/write. On a tick, an enabled timer with a nonzero counter decrements by one. A disabled timer holds its counter.
- R4: An enabled timer at 0 on a tick underflows. With restart (control bit 1) set, it reloads its counter. Otherwise it clears enable (bit 0) and stays at 0.
- R5: Writing control with bit 2 set copies the reload value into the counter. Bit 2 always reads 0.
- R6: An underflow with interrupt enable (bit 3) set sets pending (bit 4) and pulses the mapped `irq_o` line high for exactly the next cycle. Without interrupt enable, neither happens.
- R7: In clear-on-one mode (CLR_ON_ONE=1), a control write with bit 4 = 1 clears pending and bit 4 = 0 leaves it.
- R8: In clear-on-zero mode (CLR_ON_ONE=0), a control write with bit 4 = 0 clears pending and bit 4 = 1 leaves it.
- R9: With SEP_IRQ=0, every timer pulses line `IRQ_CFG[4:0]`. With SEP_IRQ=1, timer n pulses line `IRQ_CFG[4:0]`+n, and a timer whose line number exceeds 31 drives none.
- R10: Address 0x08 reads the timer count in bits 2:0, the base line in bits 7:3, the separate-lines flag in bit 8, and a constant 1 in bit 9; writes to it have no effect.
- R11: Control bit 5 (debug halt) always reads 0. Addresses of timers beyond NUM_CH, and unused words, read 0 and ignore writes.
- R12: In one cycle, an underflow sets pending even if the same cycle's write would clear it. A counter or control write overrides the tick's update of the counter and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; a write commits when psel, penable and pwrite are high |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address; bits 1:0 ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq_o | output | 32 | Interrupt pulse vector |

## Verification
The hardest situation to reach is a register write in the same cycle as a tick and an underflow. Examples are a pending-clear racing a new underflow, or a control write landing while a timer sits at zero. Directed steps can only hit these by chance. The bench therefore sets the scaler reload and the timer reloads to tiny values so ticks and underflows fire almost every cycle. A long pseudo-random stream of writes and reads then follows. A behavioural model checks every cycle, so each collision that occurs is compared.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int MAX_CH = 7;
  localparam int B_EN   = 0;
  localparam int B_RS   = 1;
  localparam int B_LD   = 2;
  localparam int B_IE   = 3;
  localparam int B_PD   = 4;

  // Pending-clear decision for the written bit under the build-time mode
  function automatic logic pend_clear(input logic wbit, input bit clr_on_one);
    return clr_on_one ? wbit : !wbit;
  endfunction

  // Control word as seen by software; load and debug-halt read as 0
  function automatic logic [31:0] ctl_word(input logic en, input logic rs,
                                           input logic ie, input logic pd);
    logic [31:0] w;
    w = '0;
    w[B_EN] = en;
    w[B_RS] = rs;
    w[B_IE] = ie;
    w[B_PD] = pd;
    return w;
  endfunction

  function automatic logic [31:0] cfg_word(input int n_ch, input logic [4:0] base,
                                           input bit sep);
    return {22'd0, 1'b1, sep, base, 3'(n_ch)};
  endfunction

  // Route per-timer pulses onto the 32-line vector
  function automatic logic [31:0] irq_map(input logic [MAX_CH-1:0] pulse,
                                          input int n_ch, input logic [4:0] base,
                                          input bit sep);
    logic [31:0] v;
    int idx;
    v = '0;
    for (int i = 0; i < MAX_CH; i++) begin
      idx = int'(base) + (sep ? i : 0);
      if (i < n_ch && idx < 32 && pulse[i]) v[idx[4:0]] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_val,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic [W-1:0] rld,
  output logic         tick
);
  assign tick = (value == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      rld   <= '0;
    end else begin
      if (wr_rld) rld <= wdata;
      if (wr_val)    value <= wdata;
      else if (tick) value <= rld;
      else           value <= value - 1'b1;
    end
  end

  assert_tick_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_val |=> value == $past(rld));
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_val |=> value == $past(value) - 1'b1);
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter bit CLR_ON_ONE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_cnt,
  input  logic        wr_rld,
  input  logic        wr_ctl,
  input  logic [31:0] wdata,
  output logic [31:0] cnt,
  output logic [31:0] rld,
  output logic [31:0] ctl,
  output logic        irq_pulse,
  output logic        unf
);
  logic en, rs, ie, pd;
  logic load_req;

  assign unf      = tick && en && (cnt == '0);
  assign load_req = wr_ctl && wdata[B_LD];
  assign ctl      = ctl_word(en, rs, ie, pd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rld <= '0;
      en <= 1'b0; rs <= 1'b0; ie <= 1'b0; pd <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      if (wr_rld) rld <= wdata;
      if (wr_cnt)          cnt <= wdata;
      else if (load_req)   cnt <= rld;
      else if (tick && en) cnt <= (cnt == '0) ? (rs ? rld : '0) : cnt - 1'b1;
      if (wr_ctl) begin
        en <= wdata[B_EN];
        rs <= wdata[B_RS];
        ie <= wdata[B_IE];
      end else if (unf && !rs) begin
        en <= 1'b0;
      end
      if (unf && ie)                                   pd <= 1'b1;
      else if (wr_ctl && pend_clear(wdata[B_PD], CLR_ON_ONE)) pd <= 1'b0;
      irq_pulse <= unf && ie;
    end
  end

  assert_restart_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf && rs && !wr_cnt && !load_req |=> cnt == $past(rld));
  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !rs && !wr_ctl |=> !en);
  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_cnt && !wr_ctl |=> $stable(cnt));
  assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && !wr_cnt |=> cnt == $past(rld));
  assert_pend_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    unf && ie |=> pd && irq_pulse);
  assert_pulse_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> pd);
endmodule

// File: rtl/ptmr_unit.sv
module ptmr_unit
  import ptmr_pkg::*;
#(
  parameter int          NUM_CH     = 4,
  parameter bit          CLR_ON_ONE = 1'b1,
  parameter bit          SEP_IRQ    = 1'b0,
  parameter logic [31:0] IRQ_CFG    = 32'd5,
  parameter int          SCALER_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic [31:0] irq_o
);
  localparam logic [4:0]  BASE = IRQ_CFG[4:0];
  localparam logic [31:0] CFG  = cfg_word(NUM_CH, BASE, SEP_IRQ);

  logic [5:0]          word;
  logic                wr;
  logic                tick;
  logic [SCALER_W-1:0] sc_val, sc_rld;
  logic [31:0]         cnt_a [MAX_CH];
  logic [31:0]         rld_a [MAX_CH];
  logic [31:0]         ctl_a [MAX_CH];
  logic [MAX_CH-1:0]   pulse_v;
  logic [MAX_CH-1:0]   unf_v;
  logic [1:0]          unused_addr;
  logic [26:0]         unused_cfg;

  assign unused_addr = paddr[1:0];
  assign unused_cfg  = IRQ_CFG[31:5];
  assign word = paddr[7:2];
  assign wr   = psel && penable && pwrite;

  ptmr_prescaler #(.W(SCALER_W)) u_scaler (
    .clk(clk), .rst_n(rst_n),
    .wr_val(wr && word == 6'd0), .wr_rld(wr && word == 6'd1),
    .wdata(pwdata[SCALER_W-1:0]),
    .value(sc_val), .rld(sc_rld), .tick(tick)
  );

  for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
    localparam logic [3:0] SLOT = 4'(g + 1);
    if (g < NUM_CH) begin : g_on
      ptmr_channel #(.CLR_ON_ONE(CLR_ON_ONE)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_cnt(wr && word == {SLOT, 2'd0}),
        .wr_rld(wr && word == {SLOT, 2'd1}),
        .wr_ctl(wr && word == {SLOT, 2'd2}),
        .wdata(pwdata),
        .cnt(cnt_a[g]), .rld(rld_a[g]), .ctl(ctl_a[g]),
        .irq_pulse(pulse_v[g]), .unf(unf_v[g])
      );
    end else begin : g_off
      assign cnt_a[g]   = '0;
      assign rld_a[g]   = '0;
      assign ctl_a[g]   = '0;
      assign pulse_v[g] = 1'b0;
      assign unf_v[g]   = 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (word == 6'd0) prdata = 32'(sc_val);
    if (word == 6'd1) prdata = 32'(sc_rld);
    if (word == 6'd2) prdata = CFG;
    for (int i = 0; i < MAX_CH; i++) begin
      if (word[5:2] == 4'(i + 1)) begin
        case (word[1:0])
          2'd0:    prdata = cnt_a[i];
          2'd1:    prdata = rld_a[i];
          2'd2:    prdata = ctl_a[i];
          default: prdata = '0;
        endcase
      end
    end
  end

  assign irq_o = irq_map(pulse_v, NUM_CH, BASE, SEP_IRQ);

  assert_cfg_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word == 6'd2 |-> prdata[9] && prdata[2:0] == 3'(NUM_CH));
  assert_unimpl_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(word[5:2]) > NUM_CH |-> prdata == '0);
  assert_irq_follows_unf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_v == '0 |=> pulse_v == '0);
  if (!SEP_IRQ) begin : g_shared_chk
    assert_shared_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_o) <= 1);
  end
endmodule

// File: tb/test_ptmr_unit.sv
module ptmr_ref #(
  parameter int          N     = 4,
  parameter bit          CLR1  = 1'b1,
  parameter bit          SEP   = 1'b0,
  parameter logic [31:0] BCFG  = 32'd5,
  parameter int          SCW   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] exp_rd,
  output logic [31:0] exp_irq
);
  logic [31:0] m_cnt [7];
  logic [31:0] m_rld [7];
  bit m_en [7];
  bit m_rs [7];
  bit m_ie [7];
  bit m_pd [7];
  bit m_pl [7];
  logic [31:0] m_sc, m_scr;
  logic [31:0] smask;
  int base;

  initial begin
    smask = (SCW >= 32) ? 32'hFFFF_FFFF : ((32'd1 << SCW) - 32'd1);
    base  = int'(BCFG & 32'd31);
  end

  always @(posedge clk or negedge rst_n) begin
    bit tk, wrq, u, hit;
    int wa, sub;
    if (!rst_n) begin
      m_sc = 0; m_scr = 0;
      for (int c = 0; c < 7; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_en[c] = 0; m_rs[c] = 0;
        m_ie[c] = 0; m_pd[c] = 0; m_pl[c] = 0;
      end
    end else begin
      tk  = (m_sc == 0);
      wrq = psel && penable && pwrite;
      wa  = int'(paddr) / 4;
      sub = wa % 4;
      if (wrq && wa == 0) m_sc = pwdata & smask;
      else if (tk) m_sc = m_scr;
      else m_sc = m_sc - 1;
      if (wrq && wa == 1) m_scr = pwdata & smask;
      for (int c = 0; c < N; c++) begin
        hit = wrq && (wa / 4 == c + 1);
        u = tk && m_en[c] && (m_cnt[c] == 0);
        m_pl[c] = u && m_ie[c];
        if (hit && sub == 0) m_cnt[c] = pwdata;
        else if (hit && sub == 2 && pwdata[2]) m_cnt[c] = m_rld[c];
        else if (tk && m_en[c]) begin
          if (m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
          else if (m_rs[c]) m_cnt[c] = m_rld[c];
        end
        if (u && m_ie[c]) m_pd[c] = 1;
        else if (hit && sub == 2 && (CLR1 ? pwdata[4] : !pwdata[4])) m_pd[c] = 0;
        if (hit && sub == 2) begin
          m_en[c] = pwdata[0]; m_rs[c] = pwdata[1]; m_ie[c] = pwdata[3];
        end else if (u && !m_rs[c]) m_en[c] = 0;
        if (hit && sub == 1) m_rld[c] = pwdata;
      end
    end
  end

  always @* begin
    int ln;
    exp_irq = 0;
    for (int c = 0; c < N; c++) begin
      ln = base + (SEP ? c : 0);
      if (m_pl[c] && ln <= 31) exp_irq = exp_irq | (32'd1 << ln);
    end
  end

  always @* begin
    int w, c, s;
    w = int'(paddr) / 4; c = w / 4; s = w % 4;
    exp_rd = 0;
    if (w == 0) exp_rd = m_sc;
    else if (w == 1) exp_rd = m_scr;
    else if (w == 2) exp_rd = 32'h200 + (SEP ? 32'h100 : 0) + 32'(base * 8) + 32'(N);
    else if (c >= 1 && c <= N) begin
      if (s == 0) exp_rd = m_cnt[c-1];
      else if (s == 1) exp_rd = m_rld[c-1];
      else if (s == 2) exp_rd = 32'(m_en[c-1]) + 32'(m_rs[c-1]) * 2
                              + 32'(m_ie[c-1]) * 8 + 32'(m_pd[c-1]) * 16;
    end
  end
endmodule

module test_ptmr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, irq_o, prdata_b, irq_b;
  logic [31:0] exp_rd_a, exp_irq_a, exp_rd_b, exp_irq_b;
  int errors = 0;
  int checks = 0;
  bit live = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #4 clk = ~clk;

  ptmr_unit i_ptmr_unit (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
  );
  ptmr_unit #(.NUM_CH(7), .CLR_ON_ONE(1'b0), .SEP_IRQ(1'b1), .IRQ_CFG(32'hFFFF_FFFC))
    i_ptmr_unit_b (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b), .irq_o(irq_b)
  );
  ptmr_ref ref_a (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .exp_rd(exp_rd_a), .exp_irq(exp_irq_a)
  );
  ptmr_ref #(.N(7), .CLR1(1'b0), .SEP(1'b1), .BCFG(32'hFFFF_FFFC)) ref_b (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .exp_rd(exp_rd_b), .exp_irq(exp_irq_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Interrupt vectors of both units compared every cycle
  always @(negedge clk) begin
    if (live) begin
      check("R6 R9 irq unit A", irq_o, exp_irq_a);
      check("R6 R9 irq unit B", irq_b, exp_irq_b);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1;
    check({tag, " read A"}, prdata, exp_rd_a);
    check({tag, " read B"}, prdata_b, exp_rd_b);
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    // R1 R10 R11: reset contents, configuration constant, unused space
    for (int w = 0; w < 32; w++) bus_read(8'(w * 4), "R1 R10 R11 reset map");
    check("R1 irq idle", irq_o, 32'd0);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h08, "R10 config ignores write");
    // R2: scaler reload and free-running value
    bus_write(8'h04, 32'd3);
    bus_read(8'h04, "R2 scaler reload");
    idle(2);
    bus_read(8'h00, "R2 scaler value");
    // R3 R5 R6: periodic timer 0 with interrupts
    bus_write(8'h14, 32'd5);
    bus_write(8'h18, 32'h0000_000F);
    bus_read(8'h18, "R5 load reads zero");
    bus_read(8'h10, "R5 counter loaded");
    idle(7);
    bus_read(8'h10, "R3 counting");
    idle(30);
    bus_read(8'h18, "R6 pending set");
    // R7 R8: two clear encodings
    bus_write(8'h18, 32'h0000_001B);
    bus_read(8'h18, "R7 R8 clear with one");
    bus_write(8'h18, 32'h0000_000B);
    bus_read(8'h18, "R7 R8 clear with zero");
    // R4: one-shot timer 1 stops, restart timer 2 reloads without interrupt
    bus_write(8'h24, 32'd2);
    bus_write(8'h28, 32'h0000_000D);
    bus_write(8'h34, 32'd1);
    bus_write(8'h38, 32'h0000_0007);
    idle(40);
    bus_read(8'h20, "R4 one-shot counter");
    bus_read(8'h28, "R4 one-shot enable cleared");
    bus_read(8'h30, "R4 restart counter");
    bus_read(8'h38, "R6 no pending without enable");
    // R9 R11: timers 3..6 (B lines 31..34), absent in A
    for (int t = 3; t < 7; t++) begin
      bus_write(8'((t + 1) * 16 + 4), 32'd1);
      bus_write(8'((t + 1) * 16 + 8), 32'h0000_002F);
    end
    idle(30);
    for (int t = 3; t < 7; t++) bus_read(8'((t + 1) * 16 + 8), "R9 R11 high timers");
    bus_read(8'h60, "R11 absent counter");
    // R2: direct scaler value write
    bus_write(8'h00, 32'd20);
    bus_read(8'h00, "R2 scaler written");
    // R3: disabled timer holds
    bus_write(8'h18, 32'h0000_0010);
    bus_read(8'h10, "R3 hold first");
    idle(20);
    bus_read(8'h10, "R3 hold second");
    // R12: dense collisions of writes with ticks and underflows
    bus_write(8'h04, 32'd0);
    for (int k = 0; k < 1500; k++) begin
      logic [4:0] w;
      logic [31:0] d;
      lfsr = step(lfsr);
      w = lfsr[4:0];
      lfsr = step(lfsr);
      d = lfsr;
      if (w[1:0] != 2'd2 && w != 5'd2) d = d & 32'd3;
      if (lfsr[7]) bus_write({1'b0, w, 2'b00}, d);
      else bus_read({1'b0, w, 2'b00}, "R12 collision");
    end
    idle(4);
    live = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule